// File: doc/BRIEF.md
# Four-Function Bitwise Logic Unit

This block is a purely combinational logic unit that applies one of four bitwise operations to two operand words. It is built from identical one-bit slices placed side by side. Each slice sees one bit of each operand and produces one result bit. A single 2-bit function code is routed to every slice, so the whole word always performs the same operation.

The operation set is AND, OR, NOR and XOR. Each has a fixed code, and the encoding is part of the contract with whatever drives the code. The word width is a parameter with a default of 4 bits. The block has no clock, no reset, no carry and no status output. A datapath uses it by presenting the operands and the code and taking the result once the logic has settled.

Top module: `bitwise_alu`

## Requirements
- R1: With function code 2'b00, every result bit equals the AND of the matching operand bits.
- R2: With function code 2'b01, every result bit equals the OR of the matching operand bits.
- R3: With function code 2'b10, every result bit equals the NOR of the matching operand bits: it is 1 only where both operand bits are 0.
- R4: With function code 2'b11, every result bit equals the XOR of the matching operand bits.
- R5: Result bit i depends only on operand bits i and the function code. Toggling a single operand bit never changes any other result bit.
- R6: The width follows the WIDTH parameter (default 4). At any width, all slices apply the same function code.
- R7: With 4-bit operands A = 4'b0010 and B = 4'b0011, the results are 4'b0010 (code 00), 4'b0011 (code 01), 4'b1100 (code 10) and 4'b0001 (code 11).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand word |
| opb | input | WIDTH | Second operand word |
| fsel | input | 2 | Function code shared by all slices |
| res | output | WIDTH | Bitwise result |

## Verification
The function code and the operands can both change in the same cycle. A stale code applied to fresh operands, or the reverse, would then give a plausible but wrong word. The bench provokes this by switching the code and both operands together on one edge across all four codes. It judges the settled result half a period later against a reference built from per-operation truth tables. It also toggles single operand bits under each code to confirm that only the matching result bit can move.

// File: rtl/bitwise_alu.sv
module bitwise_alu #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [1:0]       fsel,
  output logic [WIDTH-1:0] res
);

  localparam logic [1:0] F_AND = 2'b00;
  localparam logic [1:0] F_OR  = 2'b01;
  localparam logic [1:0] F_NOR = 2'b10;
  localparam logic [1:0] F_XOR = 2'b11;

  for (genvar i = 0; i < WIDTH; i++) begin : slice_g
    logic a, b, y;
    assign a = opa[i];
    assign b = opb[i];
    assign y = fsel[1] ? (fsel[0] ? (a ^ b) : ~(a | b))
                       : (fsel[0] ? (a | b) : (a & b));
    assign res[i] = y;
  end

  always_comb begin
    if (!$isunknown({opa, opb, fsel})) begin
      if (fsel == F_AND) begin
        p_and_within_r1: assert ((res & ~(opa & opb)) == '0 && ((opa & opb) & ~res) == '0)
          else $error("R1 AND result wrong");
      end
      if (fsel == F_OR) begin
        p_or_cover_r2: assert (((opa | opb) & ~res) == '0 && (res & ~opa & ~opb) == '0)
          else $error("R2 OR result wrong");
      end
      if (fsel == F_NOR) begin
        p_nor_disjoint_r3: assert ((res & (opa | opb)) == '0 && ((~res) & ~opa & ~opb) == '0)
          else $error("R3 NOR result wrong");
      end
      if (fsel == F_XOR) begin
        p_xor_parity_r4: assert ((res & opa & opb) == '0 && (res & ~opa & ~opb) == '0
                                 && ((opa ^ opb) & ~res) == '0)
          else $error("R4 XOR result wrong");
      end
    end
  end

endmodule

// File: tb/bitwise_alu_tb_top.sv
module bitwise_alu_tb_top;
  localparam int W  = 4;
  localparam int WW = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0]  a, b, y;
  logic [WW-1:0] wa, wb, wy;
  logic [1:0]    f;
  int errs = 0;
  int checks = 0;

  bitwise_alu #(.WIDTH(W))  dut_i  (.opa(a),  .opb(b),  .fsel(f), .res(y));
  bitwise_alu #(.WIDTH(WW)) wide_i (.opa(wa), .opb(wb), .fsel(f), .res(wy));

  function automatic logic [15:0] model(input logic [15:0] x, input logic [15:0] z,
                                        input logic [1:0] code);
    logic [3:0] tt;
    logic [15:0] r;
    case (code)
      2'b00: tt = 4'b1000;
      2'b01: tt = 4'b1110;
      2'b10: tt = 4'b0001;
      default: tt = 4'b0110;
    endcase
    for (int k = 0; k < 16; k++) r[k] = tt[{x[k], z[k]}];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] z, input logic [1:0] code);
    @(posedge clk);
    a = x; b = z; f = code;
    @(negedge clk);
  endtask

  function automatic string tag_of(input logic [1:0] code);
    case (code)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic t_quiet;
    apply('0, '0, 2'b00);
    chk("R1 zero operands", 16'(y), 16'h0);
    apply('0, '0, 2'b10);
    chk("R3 zero operands", 16'(y), 16'hF);
  endtask

  task automatic t_example;
    apply(4'b0010, 4'b0011, 2'b00); chk("R7 and", 16'(y), 16'h2);
    apply(4'b0010, 4'b0011, 2'b01); chk("R7 or",  16'(y), 16'h3);
    apply(4'b0010, 4'b0011, 2'b10); chk("R7 nor", 16'(y), 16'hC);
    apply(4'b0010, 4'b0011, 2'b11); chk("R7 xor", 16'(y), 16'h1);
  endtask

  task automatic t_sweep;
    for (int c = 0; c < 4; c++)
      for (int x = 0; x < 16; x++)
        for (int z = 0; z < 16; z++) begin
          apply(4'(x), 4'(z), 2'(c));
          chk(tag_of(2'(c)), 16'(y), model(16'(x), 16'(z), 2'(c)) & 16'hF);
        end
  endtask

  task automatic t_isolation;
    logic [W-1:0] base;
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < W; k++) begin
        apply(4'b0101, 4'b0110, 2'(c));
        base = y;
        apply(4'b0101 ^ (4'b1 << k), 4'b0110, 2'(c));
        chk("R5 other bits still", 16'((y ^ base) & ~(4'b1 << k)), 16'h0);
        apply(4'b0101, 4'b0110 ^ (4'b1 << k), 2'(c));
        chk("R5 other bits still b", 16'((y ^ base) & ~(4'b1 << k)), 16'h0);
      end
  endtask

  task automatic t_wide;
    for (int c = 0; c < 4; c++) begin
      @(posedge clk);
      wa = 7'b1010011; wb = 7'b0110101; f = 2'(c);
      @(negedge clk);
      chk("R6 wide", 16'(wy), model(16'(wa), 16'(wb), 2'(c)) & 16'h7F);
    end
  endtask

  task automatic t_simultaneous;
    logic [W-1:0] xs [4] = '{4'hA, 4'h3, 4'hF, 4'h6};
    logic [W-1:0] zs [4] = '{4'h5, 4'hC, 4'h0, 4'h6};
    for (int i = 0; i < 4; i++) begin
      apply(xs[i], zs[i], 2'(3 - i));
      chk(tag_of(2'(3 - i)), 16'(y), model(16'(xs[i]), 16'(zs[i]), 2'(3 - i)) & 16'hF);
    end
  endtask

  initial begin
    a = '0; b = '0; f = '0; wa = '0; wb = '0;
    t_quiet();
    t_example();
    t_simultaneous();
    t_isolation();
    t_wide();
    t_sweep();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1000000;
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule